// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block sits in the configuration space of a host bridge. It holds one 64-bit register that places the memory-mapped PCIe configuration window in the system address map. From that register it derives four things: whether the window is on, its aligned base, and its length (256 MB, 128 MB or 64 MB). The fourth is the address where the 32-bit PCI memory hole starts.

Software reaches the register through a 32-bit register port. The port has a dword select and four byte-lane enables, and reads return data in the same cycle. A write that touches the register schedules a re-decode. The decoded state then drives a combinational hit output for a 36-bit memory address, and it also drives the hole-start output. Reset loads a fixed default base with the window switched off.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register reads back the default base (0xB000_0000 in bits [35:0], all other bits zero). The window is off, no address hits, and the hole start equals the default base.
- R2: Register layout:
  - bit 0 is the window enable;
  - bits [2:1] are the size code;
  - bits [35:26] are writable base bits;
  - every other bit reads zero and ignores writes.
  Writing all ones therefore reads back 0xFC00_0007 in dword 0 and 0x0000_000F in dword 1.
- R3: A write changes only the byte lanes whose enable bit is set, in the dword chosen by the select (0 = bits [31:0], 1 = bits [63:32]). A write with no lane enabled changes nothing.
- R4: With the enable bit clear, no address hits.
- R5: Size code 00 gives a 256 MB window. The base is the register's bits [35:28]; bits [27:26] are ignored.
- R6: Size code 01 gives a 128 MB window. The base is the register's bits [35:27].
- R7: Size code 10 gives a 64 MB window. The base is the register's bits [35:26].
- R8: Size code 11 is reserved. It turns the window off and reports a length of zero, whatever the enable bit holds.
- R9: When the window is on, the hole start (37 bits) equals base plus length. When it is off, the hole start is the default base.
- R10: The register reads back the written value right after the accepting clock edge. The decoded outputs (enable, base, length, hit, hole start) change at the following edge and hold at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_dw | input | 1 | Write dword select (0 low, 1 high) |
| cfg_wr_be | input | 4 | Write byte-lane enables |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_dw | input | 1 | Read dword select |
| cfg_rd_data | output | 32 | Read data of the selected dword |
| mem_addr | input | 36 | Memory address to match |
| win_hit | output | 1 | Address falls inside the enabled window |
| win_enable | output | 1 | Decoded window enable |
| win_base | output | 36 | Decoded aligned base |
| win_len | output | 37 | Decoded window length in bytes |
| hole_start | output | 37 | Start of the 32-bit PCI memory hole |

## Verification
Corrupt register state shows up at the read port in the same cycle as the write. A wrong decode shows on the window outputs and the hit line one edge later. A stale or mis-masked base shows up as a hit just below the window, or as a miss at its last byte, or as a hole start that is off by the window length. Those boundary addresses are probed for every size code over a sweep of base values. A wrong size decode appears at once as a length or mask error at the ports. A lost refresh leaves the old hit value standing for a whole cycle after the write.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int unsigned CW_REG_W     = 64;
    localparam int unsigned CW_DW_W      = 32;
    localparam int unsigned CW_LANES     = CW_DW_W / 8;
    localparam int unsigned CW_EN_BIT    = 0;
    localparam int unsigned CW_SZ_LSB    = 1;
    localparam int unsigned CW_CTRL_BITS = 3;

    typedef enum logic [1:0] {
        WSZ_FULL    = 2'b00,
        WSZ_HALF    = 2'b01,
        WSZ_QUARTER = 2'b10,
        WSZ_RSVD    = 2'b11
    } win_size_e;

    // how many binary steps below the largest window a size code sits
    function automatic int unsigned cw_shrink(win_size_e s);
        case (s)
            WSZ_HALF:    return 1;
            WSZ_QUARTER: return 2;
            default:     return 0;
        endcase
    endfunction

    // bits of the register that hold state
    function automatic logic [CW_REG_W-1:0] cw_keep_mask(int unsigned addr_w,
                                                         int unsigned base_lsb);
        logic [CW_REG_W-1:0] m;
        m = '0;
        for (int unsigned b = 0; b < CW_REG_W; b++) begin
            if (b < CW_CTRL_BITS || (b >= base_lsb && b < addr_w))
                m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cfgwin_regfile.sv
module cfgwin_regfile
    import cfgwin_pkg::*;
#(
    parameter int unsigned ADDR_W       = 36,
    parameter int unsigned MAX_WIN_LOG2 = 28,
    parameter logic [CW_REG_W-1:0] RESET_REG = 64'h0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_dw,
    input  logic [CW_LANES-1:0]  wr_be,
    input  logic [CW_DW_W-1:0]   wr_data,
    input  logic                 rd_dw,
    output logic [CW_DW_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]    win_reg,
    output logic                 refresh
);

    localparam int unsigned BASE_LSB = MAX_WIN_LOG2 - 2;
    localparam int unsigned NBYTES   = CW_REG_W / 8;
    localparam logic [CW_REG_W-1:0] KEEP = cw_keep_mask(ADDR_W, BASE_LSB);

    logic [CW_REG_W-1:0] reg_q;
    logic                refresh_q;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        localparam logic    LANE_DW = 1'((g / CW_LANES) != 0);
        localparam int unsigned LANE = g % CW_LANES;
        logic lane_wr;
        assign lane_wr = wr_en && wr_be[LANE] && (wr_dw == LANE_DW);
        always_ff @(posedge clk) begin
            if (rst)
                reg_q[g*8 +: 8] <= RESET_REG[g*8 +: 8];
            else if (lane_wr)
                reg_q[g*8 +: 8] <= wr_data[LANE*8 +: 8] & KEEP[g*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) refresh_q <= 1'b0;
        else     refresh_q <= wr_en && (|wr_be);
    end

    assign rd_data = rd_dw ? reg_q[CW_REG_W-1:CW_DW_W] : reg_q[CW_DW_W-1:0];
    assign win_reg = reg_q[ADDR_W-1:0];
    assign refresh = refresh_q;

    assert_void_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_q & ~KEEP) == '0);

    assert_no_lane_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_be == '0) |=> $stable(reg_q));

    assert_reset_load_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (reg_q == RESET_REG));

endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
    import cfgwin_pkg::*;
#(
    parameter int unsigned ADDR_W       = 36,
    parameter int unsigned MAX_WIN_LOG2 = 28,
    parameter logic [ADDR_W-1:0] RESET_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] win_reg,
    input  logic              refresh,
    output logic              dec_en,
    output logic [ADDR_W-1:0] dec_base,
    output logic [ADDR_W-1:0] dec_mask,
    output logic [ADDR_W:0]   dec_len
);

    localparam logic [ADDR_W-1:0] ONES    = '1;
    localparam logic [ADDR_W:0]   LEN_ONE = (ADDR_W+1)'(1);

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W:0]   len;
    } dec_t;

    function automatic dec_t decode_fn(logic [ADDR_W-1:0] r);
        dec_t        d;
        win_size_e   sz;
        int unsigned lg;
        sz     = win_size_e'(r[CW_SZ_LSB +: 2]);
        lg     = MAX_WIN_LOG2 - cw_shrink(sz);
        d.mask = ONES << lg;
        d.base = r & d.mask;
        d.en   = r[CW_EN_BIT] && (sz != WSZ_RSVD);
        d.len  = (sz == WSZ_RSVD) ? '0 : (LEN_ONE << lg);
        return d;
    endfunction

    localparam dec_t RESET_DEC = decode_fn(RESET_BASE & (ONES << CW_CTRL_BITS));

    dec_t dec_q;

    always_ff @(posedge clk) begin
        if (rst)          dec_q <= RESET_DEC;
        else if (refresh) dec_q <= decode_fn(win_reg);
    end

    assign dec_en   = dec_q.en;
    assign dec_base = dec_q.base;
    assign dec_mask = dec_q.mask;
    assign dec_len  = dec_q.len;

    assert_rsvd_off_R8: assert property (@(posedge clk) disable iff (rst)
        (refresh && win_reg[CW_SZ_LSB +: 2] == 2'b11) |=> (!dec_q.en && dec_q.len == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !refresh |=> $stable(dec_q));

endmodule

// File: rtl/cfgwin_match.sv
module cfgwin_match #(
    parameter int unsigned ADDR_W = 36,
    parameter logic [ADDR_W-1:0] RESET_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_en,
    input  logic [ADDR_W-1:0] dec_base,
    input  logic [ADDR_W-1:0] dec_mask,
    input  logic [ADDR_W:0]   dec_len,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              hit,
    output logic [ADDR_W:0]   hole_start
);

    logic [ADDR_W:0] win_end;
    logic            in_field;
    logic            below_end;

    assign win_end    = {1'b0, dec_base} + dec_len;
    assign in_field   = (mem_addr & dec_mask) == dec_base;
    assign below_end  = {1'b0, mem_addr} < win_end;
    assign hit        = dec_en && in_field && below_end;
    assign hole_start = dec_en ? win_end : {1'b0, RESET_BASE};

    assert_hit_above_base_R5: assert property (@(posedge clk) disable iff (rst)
        hit |-> (mem_addr >= dec_base));

    assert_hit_below_hole_R9: assert property (@(posedge clk) disable iff (rst)
        hit |-> ({1'b0, mem_addr} < hole_start));

endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
    import cfgwin_pkg::*;
#(
    parameter int unsigned ADDR_W       = 36,
    parameter int unsigned MAX_WIN_LOG2 = 28,
    parameter logic [ADDR_W-1:0] RESET_BASE = 36'h0_B000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_dw,
    input  logic [3:0]        cfg_wr_be,
    input  logic [31:0]       cfg_wr_data,
    input  logic              cfg_rd_dw,
    output logic [31:0]       cfg_rd_data,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              win_hit,
    output logic              win_enable,
    output logic [ADDR_W-1:0] win_base,
    output logic [ADDR_W:0]   win_len,
    output logic [ADDR_W:0]   hole_start
);

    localparam int unsigned BASE_LSB = MAX_WIN_LOG2 - 2;
    localparam logic [CW_REG_W-1:0] RESET_REG =
        cw_keep_mask(ADDR_W, BASE_LSB) & CW_REG_W'(RESET_BASE)
        & ~CW_REG_W'((1 << CW_CTRL_BITS) - 1);

    logic [ADDR_W-1:0] win_reg;
    logic              refresh;
    logic [ADDR_W-1:0] dec_mask;

    cfgwin_regfile #(
        .ADDR_W(ADDR_W), .MAX_WIN_LOG2(MAX_WIN_LOG2), .RESET_REG(RESET_REG)
    ) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(cfg_wr_en), .wr_dw(cfg_wr_dw), .wr_be(cfg_wr_be), .wr_data(cfg_wr_data),
        .rd_dw(cfg_rd_dw), .rd_data(cfg_rd_data),
        .win_reg(win_reg), .refresh(refresh)
    );

    cfgwin_decode #(
        .ADDR_W(ADDR_W), .MAX_WIN_LOG2(MAX_WIN_LOG2), .RESET_BASE(RESET_BASE)
    ) u_dec (
        .clk(clk), .rst(rst), .win_reg(win_reg), .refresh(refresh),
        .dec_en(win_enable), .dec_base(win_base), .dec_mask(dec_mask), .dec_len(win_len)
    );

    cfgwin_match #(
        .ADDR_W(ADDR_W), .RESET_BASE(RESET_BASE)
    ) u_match (
        .clk(clk), .rst(rst),
        .dec_en(win_enable), .dec_base(win_base), .dec_mask(dec_mask), .dec_len(win_len),
        .mem_addr(mem_addr), .hit(win_hit), .hole_start(hole_start)
    );

    // a refresh that captures a cleared enable bit silences the hit line
    assert_off_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (refresh && !win_reg[CW_EN_BIT]) |=> !win_hit);

endmodule

// File: tb/tb_cfgwin_decoder.sv
module tb_cfgwin_decoder;

    localparam int CLK_PERIOD = 10;
    localparam logic [35:0] RST_BASE = 36'h0_B000_0000;
    localparam logic [63:0] KEEP     = 64'h0000_000F_FC00_0007;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_dw = 1'b0;
    logic [3:0]  wr_be = 4'h0;
    logic [31:0] wr_data = '0;
    logic        rd_dw = 1'b0;
    logic [31:0] rd_data;
    logic [35:0] mem_addr = '0;
    logic        win_hit;
    logic        win_enable;
    logic [35:0] win_base;
    logic [36:0] win_len;
    logic [36:0] hole_start;

    int   nchk  = 0;
    int   nfail = 0;
    logic [63:0] model = 64'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgwin_decoder dut (
        .clk(clk), .rst(rst),
        .cfg_wr_en(wr_en), .cfg_wr_dw(wr_dw), .cfg_wr_be(wr_be), .cfg_wr_data(wr_data),
        .cfg_rd_dw(rd_dw), .cfg_rd_data(rd_data),
        .mem_addr(mem_addr), .win_hit(win_hit), .win_enable(win_enable),
        .win_base(win_base), .win_len(win_len), .hole_start(hole_start)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_dw = dw; wr_be = be; wr_data = d;
        for (int b = 0; b < 4; b++) begin
            int idx;
            idx = (dw ? 4 : 0) + b;
            if (be[b]) model[idx*8 +: 8] = d[b*8 +: 8] & KEEP[idx*8 +: 8];
        end
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0;
    endtask

    task automatic load(input logic [63:0] v);
        wr(1'b0, 4'hF, v[31:0]);
        wr(1'b1, 4'hF, v[63:32]);
        @(negedge clk);
    endtask

    task automatic readback(input string tag);
        rd_dw = 1'b0; #1;
        chk(tag, 64'(rd_data), 64'(model[31:0]));
        rd_dw = 1'b1; #1;
        chk(tag, 64'(rd_data), 64'(model[63:32]));
        rd_dw = 1'b0;
    endtask

    task automatic check_decode(input string tag);
        logic [1:0]  code;
        logic [36:0] len;
        logic [36:0] base;
        logic [36:0] amask;
        logic [36:0] a37;
        logic [35:0] a;
        logic        en;
        logic        eh;
        code = model[2:1];
        case (code)
            2'd0:    len = 37'h1 << 28;
            2'd1:    len = 37'h1 << 27;
            2'd2:    len = 37'h1 << 26;
            default: len = '0;
        endcase
        en    = model[0] && (code != 2'd3);
        amask = (code == 2'd3) ? ((37'h1 << 28) - 1) : (len - 1);
        base  = {1'b0, model[35:0]} & ~amask;
        chk(tag, 64'(win_enable), 64'(en));
        chk(tag, 64'(win_len), 64'(len));
        if (en) chk(tag, 64'(win_base), 64'(base[35:0]));
        chk("R9", 64'(hole_start), en ? 64'(base + len) : 64'(RST_BASE));
        for (int p = 0; p < 6; p++) begin
            case (p)
                0: a37 = base - 1;
                1: a37 = base;
                2: a37 = base + len - 1;
                3: a37 = base + len;
                4: a37 = base + (len >> 1);
                default: a37 = base ^ (37'h1 << 35);
            endcase
            a = a37[35:0];
            mem_addr = a; #1;
            eh = en && ({1'b0, a} >= base) && ({1'b0, a} < base + len);
            chk(tag, 64'(win_hit), 64'(eh));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nfail++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        string tg;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model = {28'h0, RST_BASE};
        @(negedge clk);

        // R1: reset state
        rd_dw = 1'b0; #1; chk("R1", 64'(rd_data), 64'hB000_0000);
        rd_dw = 1'b1; #1; chk("R1", 64'(rd_data), 64'h0);
        rd_dw = 1'b0;
        chk("R1", 64'(win_enable), 64'h0);
        chk("R1", 64'(hole_start), 64'(RST_BASE));
        mem_addr = RST_BASE; #1; chk("R1", 64'(win_hit), 64'h0);

        // R2: all ones written, only live bits stick; code 11 is reserved
        wr(1'b0, 4'hF, 32'hFFFF_FFFF);
        wr(1'b1, 4'hF, 32'hFFFF_FFFF);
        rd_dw = 1'b0; #1; chk("R2", 64'(rd_data), 64'hFC00_0007);
        rd_dw = 1'b1; #1; chk("R2", 64'(rd_data), 64'h0000_000F);
        rd_dw = 1'b0;
        @(negedge clk);
        check_decode("R8");

        // R3: lane enables and dword select
        load(64'h0000_0005_8400_0003);
        wr(1'b0, 4'b1000, 32'h0000_0000);
        readback("R3");
        wr(1'b1, 4'b0000, 32'hFFFF_FFFF);
        readback("R3");
        wr(1'b0, 4'b0110, 32'hFFFF_FFFF);
        readback("R3");
        @(negedge clk);
        check_decode("R6");

        // R10: read back at once, decode one edge later
        load(64'h0000_0000_4000_0001);
        mem_addr = 36'h0_4000_0010; #1;
        chk("R10", 64'(win_hit), 64'h1);
        wr(1'b0, 4'b0001, 32'h0000_0000);
        rd_dw = 1'b0; #1;
        chk("R10", 64'(rd_data), 64'h4000_0000);
        chk("R10", 64'(win_hit), 64'h1);
        @(negedge clk); #1;
        chk("R10", 64'(win_hit), 64'h0);
        chk("R4", 64'(win_enable), 64'h0);

        // sweep: every size code, both enables, bases across the field
        for (int f = 0; f < 1024; f += 31) begin
            for (int c = 0; c < 4; c++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [63:0] v;
                    v = (64'(f) << 26) | (64'(c) << 1) | 64'(e);
                    load(v);
                    if (c == 3)      tg = "R8";
                    else if (e == 0) tg = "R4";
                    else if (c == 0) tg = "R5";
                    else if (c == 1) tg = "R6";
                    else             tg = "R7";
                    check_decode(tg);
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule